// File: doc/BRIEF.md
# HDLC Tone-Select Framer with Bit Stuffing

This block turns a stream of packet bytes into the bit sequence that drives a two-tone packet-radio transmitter. A frame opens with a run of flag bytes (0x7E), carries the payload bytes with a 0 inserted after every run of five 1 bits, and closes with a flag. Every bit, whether flag, data or inserted, is NRZI coded onto a single tone-select level. A 0 bit flips the level and a 1 bit leaves it where it is.

The tone generator paces the block. Each pulse on `sym_adv` consumes exactly one bit. Payload bytes come in over a valid/ready handshake, and a last marker ends the payload. A frame is started by a pulse on `start`. The `no_payload` input, sampled with that pulse, selects a frame made only of flags. The CRC, the address fields and the modulation itself are not part of this block. Frame check bytes are sent as ordinary payload.

Top module: `hdlc_tone_framer`

## Requirements
- R1: After reset, `tone`, `busy`, `done` and `in_ready` are all 0.
- R2: A `start` pulse while idle raises `busy` in the next cycle. The following `sym_adv` pulses emit 20 opening flags of value 0x7E, one bit per pulse.
- R3: Encoding is NRZI on `tone`. An emitted 0 inverts `tone` and an emitted 1 keeps it. `tone` changes only in the cycle after a `sym_adv` edge that emits a bit.
- R4: Every byte, flags included, is sent least significant bit (bit 0) first. `in_ready` rises only after the final bit of the last opening flag, or of the previous payload byte, has been emitted. It stays high until `in_valid` is seen, and a byte is taken on a clock edge where both are high.
- R5: Within the payload, once five consecutive 1 bits have been emitted, the next `sym_adv` emits an inserted 0 before the next data bit. The run of ones is counted across byte boundaries.
- R6: The run-of-ones count is cleared when the payload starts and when it ends. No flag bit is ever stuffed, and a payload that ends in five 1 bits is followed directly by the closing flag.
- R7: After the byte marked `in_last`, one closing flag is sent. In the cycle after the edge that emits its last bit, `done` is high for exactly one cycle and `busy` is low.
- R8: When `no_payload` is high with `start`, the closing flag follows the opening flags directly and `in_ready` never rises.
- R9: A `sym_adv` pulse that arrives while `in_ready` is high emits no bit and leaves `tone` unchanged.
- R10: A `start` pulse while `busy` is high has no effect on the frame in progress.
- R11: `tone` is not reset when a frame starts. Each frame continues from the level the previous frame left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start pulse, accepted only while idle |
| no_payload | input | 1 | Sampled with `start`: the frame carries no payload bytes |
| sym_adv | input | 1 | One-cycle pulse from the tone generator; advances one symbol |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | The presented byte is the final payload byte |
| in_ready | output | 1 | Block is waiting for the next payload byte |
| tone | output | 1 | NRZI tone-select level |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the last closing-flag bit |

## Verification
The case that needs the most care is a stuffed bit that falls exactly at a byte boundary, at the same point where the next byte is being requested. The bench sends a byte whose top five bits are ones and follows it with another byte. It expects the first `sym_adv` after the handover to produce the inserted 0. When the byte with five trailing ones is the last one, it expects no inserted 0. A second coincidence is a `sym_adv` pulse, with or without `in_valid`, arriving in the same cycle that `in_ready` is high. The bench judges this by requiring `tone` to stay still and the emitted bit sequence to remain intact. Both cases are compared bit by bit against a sequence the bench builds from the requirements.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPEN,
      ST_FETCH,
      ST_DATA,
      ST_CLOSE
   } frm_state_e;

endpackage

// File: rtl/hdlc_stuff_track.sv
module hdlc_stuff_track #(
   parameter int STUFF_RUN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic count_en,
   input  logic bit_in,
   output logic need_stuff
);
   localparam int CW = $clog2(STUFF_RUN + 1);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_cnt <= '0;
      else if (clr)
         run_cnt <= '0;
      else if (count_en)
         run_cnt <= bit_in ? run_cnt + CW'(1) : '0;
   end

   assign need_stuff = (run_cnt == CW'(STUFF_RUN));

   // the run never grows past the stuffing threshold
   p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= CW'(STUFF_RUN));

endmodule

// File: rtl/hdlc_nrzi_level.sv
module hdlc_nrzi_level (
   input  logic clk,
   input  logic rst_n,
   input  logic emit,
   input  logic emit_bit,
   output logic tone
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         tone <= 1'b0;
      else if (emit && !emit_bit)
         tone <= ~tone;
   end
endmodule

// File: rtl/hdlc_frame_seq.sv
module hdlc_frame_seq
   import hdlc_tx_pkg::*;
#(
   parameter int              DATA_W      = 8,
   parameter logic [DATA_W-1:0] FLAG_CODE = 'h7E,
   parameter int              OPEN_FLAGS  = 20,
   parameter int              CLOSE_FLAGS = 1,
   parameter bit              LSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              no_payload,
   input  logic              sym_adv,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_last,
   input  logic              need_stuff,
   output logic              in_ready,
   output logic              emit,
   output logic              emit_bit,
   output logic              pay_count,
   output logic              cnt_clr,
   output logic              busy,
   output logic              done
);
   localparam int IDX_W  = $clog2(DATA_W);
   localparam int MAXF   = (OPEN_FLAGS > CLOSE_FLAGS) ? OPEN_FLAGS : CLOSE_FLAGS;
   localparam int FC_W   = $clog2(MAXF + 1);

   frm_state_e        state;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] sh_next;
   logic              head_bit;
   logic [IDX_W-1:0]  bit_idx;
   logic [FC_W-1:0]   flag_cnt;
   logic              last_q;
   logic              empty_q;
   logic              done_q;

   logic last_bit, last_open, last_close, open_end, byte_end;

   // bit order variant
   if (LSB_FIRST) begin : g_lsb
      assign head_bit = shreg[0];
      assign sh_next  = {1'b0, shreg[DATA_W-1:1]};
   end else begin : g_msb
      assign head_bit = shreg[DATA_W-1];
      assign sh_next  = {shreg[DATA_W-2:0], 1'b0};
   end

   assign last_bit   = (bit_idx == IDX_W'(DATA_W - 1));
   assign last_open  = (flag_cnt == FC_W'(OPEN_FLAGS - 1));
   assign last_close = (flag_cnt == FC_W'(CLOSE_FLAGS - 1));
   assign open_end   = (state == ST_OPEN) && sym_adv && last_bit && last_open;
   assign byte_end   = (state == ST_DATA) && sym_adv && !need_stuff && last_bit;

   always_comb begin
      emit      = 1'b0;
      emit_bit  = head_bit;
      pay_count = 1'b0;
      unique case (state)
         ST_OPEN, ST_CLOSE: emit = sym_adv;
         ST_DATA: begin
            emit      = sym_adv;
            pay_count = sym_adv;
            if (need_stuff) emit_bit = 1'b0;
         end
         default: ;
      endcase
   end

   assign cnt_clr  = open_end || (byte_end && last_q);
   assign in_ready = (state == ST_FETCH);
   assign busy     = (state != ST_IDLE);
   assign done     = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         bit_idx  <= '0;
         flag_cnt <= '0;
         last_q   <= 1'b0;
         empty_q  <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               state    <= ST_OPEN;
               shreg    <= FLAG_CODE;
               bit_idx  <= '0;
               flag_cnt <= '0;
               empty_q  <= no_payload;
            end
            ST_OPEN: if (sym_adv) begin
               if (last_bit) begin
                  bit_idx <= '0;
                  shreg   <= FLAG_CODE;
                  if (last_open) begin
                     flag_cnt <= '0;
                     state    <= empty_q ? ST_CLOSE : ST_FETCH;
                  end else begin
                     flag_cnt <= flag_cnt + FC_W'(1);
                  end
               end else begin
                  shreg   <= sh_next;
                  bit_idx <= bit_idx + IDX_W'(1);
               end
            end
            ST_FETCH: if (in_valid) begin
               shreg   <= in_data;
               last_q  <= in_last;
               bit_idx <= '0;
               state   <= ST_DATA;
            end
            ST_DATA: if (sym_adv && !need_stuff) begin
               if (last_bit) begin
                  bit_idx <= '0;
                  if (last_q) begin
                     state    <= ST_CLOSE;
                     shreg    <= FLAG_CODE;
                     flag_cnt <= '0;
                  end else begin
                     state <= ST_FETCH;
                  end
               end else begin
                  shreg   <= sh_next;
                  bit_idx <= bit_idx + IDX_W'(1);
               end
            end
            ST_CLOSE: if (sym_adv) begin
               if (last_bit) begin
                  bit_idx <= '0;
                  shreg   <= FLAG_CODE;
                  if (last_close) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     flag_cnt <= flag_cnt + FC_W'(1);
                  end
               end else begin
                  shreg   <= sh_next;
                  bit_idx <= bit_idx + IDX_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // an inserted bit is always a zero and is always emitted
   p_stuff_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && need_stuff && sym_adv) |-> (emit && !emit_bit));

   // the ones run is never stuffed while flags are going out
   p_flag_unstuffed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OPEN || state == ST_CLOSE) |-> !need_stuff);

endmodule

// File: rtl/hdlc_tone_framer.sv
module hdlc_tone_framer #(
   parameter int              DATA_W      = 8,
   parameter logic [DATA_W-1:0] FLAG_CODE = 'h7E,
   parameter int              OPEN_FLAGS  = 20,
   parameter int              CLOSE_FLAGS = 1,
   parameter int              STUFF_RUN   = 5,
   parameter bit              LSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              no_payload,
   input  logic              sym_adv,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_last,
   output logic              in_ready,
   output logic              tone,
   output logic              busy,
   output logic              done
);
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (OPEN_FLAGS < 1 || CLOSE_FLAGS < 1) begin : g_bad_flags
      $error("flag counts must be at least 1");
   end
   if (STUFF_RUN < 1) begin : g_bad_run
      $error("STUFF_RUN must be at least 1");
   end

   logic need_stuff, emit, emit_bit, pay_count, cnt_clr;

   hdlc_frame_seq #(
      .DATA_W      (DATA_W),
      .FLAG_CODE   (FLAG_CODE),
      .OPEN_FLAGS  (OPEN_FLAGS),
      .CLOSE_FLAGS (CLOSE_FLAGS),
      .LSB_FIRST   (LSB_FIRST)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .no_payload (no_payload),
      .sym_adv    (sym_adv),
      .in_data    (in_data),
      .in_valid   (in_valid),
      .in_last    (in_last),
      .need_stuff (need_stuff),
      .in_ready   (in_ready),
      .emit       (emit),
      .emit_bit   (emit_bit),
      .pay_count  (pay_count),
      .cnt_clr    (cnt_clr),
      .busy       (busy),
      .done       (done)
   );

   hdlc_stuff_track #(
      .STUFF_RUN (STUFF_RUN)
   ) u_stuff (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (cnt_clr),
      .count_en   (pay_count),
      .bit_in     (emit_bit),
      .need_stuff (need_stuff)
   );

   hdlc_nrzi_level u_nrzi (
      .clk      (clk),
      .rst_n    (rst_n),
      .emit     (emit),
      .emit_bit (emit_bit),
      .tone     (tone)
   );

   p_ready_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> busy);

   p_ready_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> in_ready);

   p_quiet_tone_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_adv |=> $stable(tone));

   p_wait_no_emit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && sym_adv) |=> $stable(tone));

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: tb/test_hdlc_tone_framer.sv
module test_hdlc_tone_framer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       no_payload = 1'b0;
   logic       sym_adv = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       in_last = 1'b0;
   logic       in_ready, tone, busy, done;

   always #5 clk = ~clk;

   hdlc_tone_framer i_hdlc_tone_framer (
      .clk(clk), .rst_n(rst_n), .start(start), .no_payload(no_payload),
      .sym_adv(sym_adv), .in_data(in_data), .in_valid(in_valid),
      .in_last(in_last), .in_ready(in_ready), .tone(tone), .busy(busy),
      .done(done)
   );

   localparam logic [7:0] FLAG = 8'h7E;
   localparam int N_OPEN = 20;

   int n_chk = 0;
   int n_bad = 0;
   bit summary_done = 0;

   logic [7:0] pay [0:15];
   int  pn;
   bit  eb [$];   // expected emitted bits
   bit  ef [$];   // a byte request follows this bit
   logic exp_tone = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!summary_done) begin
         summary_done = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      end
   endtask

   // expected sequence from the requirements
   function automatic void build(input bit empty);
      int c;
      bit b;
      eb.delete(); ef.delete();
      for (int f = 0; f < N_OPEN; f++)
         for (int k = 0; k < 8; k++) begin eb.push_back(FLAG[k]); ef.push_back(1'b0); end
      if (!empty) begin
         ef[ef.size()-1] = 1'b1;
         c = 0;
         for (int i = 0; i < pn; i++)
            for (int k = 0; k < 8; k++) begin
               if (c == 5) begin eb.push_back(1'b0); ef.push_back(1'b0); c = 0; end
               b = pay[i][k];
               eb.push_back(b);
               ef.push_back(k == 7 && i != pn - 1);
               c = b ? c + 1 : 0;
            end
      end
      for (int k = 0; k < 8; k++) begin eb.push_back(FLAG[k]); ef.push_back(1'b0); end
   endfunction

   task automatic run_frame(input bit empty, input bit poke);
      int  k = 0;
      int  idx = 0;
      bit  awaiting = 0;
      bit  pend = 0;
      bit  fin = 0;
      bit  first = 1;
      bit  saw_ready = 0;
      string lbl;
      int  r;
      build(empty);
      @(negedge clk);
      start = 1'b1; no_payload = empty;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0; no_payload = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      lbl = "R11 tone carried into new frame";
      while (!fin) begin
         if (pend) begin
            if (!eb[k]) exp_tone = ~exp_tone;
            if (ef[k]) awaiting = 1;
            if (k < N_OPEN * 8) lbl = "R3 opening flag tone";
            else if (k >= eb.size() - 8) lbl = "R6 closing flag tone";
            else lbl = "R5 payload tone";
            k++;
            if (k == eb.size()) fin = 1;
         end
         pend = 0;
         chk(tone == exp_tone, lbl, tone, exp_tone);
         if (in_ready) saw_ready = 1;
         chk(in_ready == awaiting, "R4 in_ready timing", in_ready, awaiting);
         if (fin) begin
            chk(done == 1'b1 && busy == 1'b0, "R7 done pulse at end", {done, busy}, 2);
            break;
         end
         if (!first) chk(done == 1'b0 && busy == 1'b1, "R7 busy during frame", {done, busy}, 1);
         first = 0;
         sym_adv = 1'b0; in_valid = 1'b0; start = 1'b0;
         lbl = "R3 tone holds";
         if (awaiting) begin
            r = $urandom % 4;
            if (r == 0) begin
               sym_adv = poke;
               if (poke) lbl = "R9 sym_adv while waiting";
            end else begin
               in_valid = 1'b1; in_data = pay[idx]; in_last = (idx == pn - 1);
               if (poke && r == 1) begin sym_adv = 1'b1; lbl = "R9 sym_adv with byte handover"; end
            end
         end else if ($urandom % 3 == 0) begin
            sym_adv = 1'b1; pend = 1;
            if (poke && ($urandom % 6 == 0)) begin start = 1'b1; end
         end
         @(posedge clk);
         if (in_valid && awaiting) begin awaiting = 0; idx++; end
         @(negedge clk);
         if (start) lbl = "R10 start while busy";
         sym_adv = 1'b0; in_valid = 1'b0; start = 1'b0;
      end
      if (empty) chk(saw_ready == 0, "R8 no byte request in empty frame", saw_ready, 0);
      else chk(idx == pn, "R4 all bytes taken", idx, pn);
      @(negedge clk);
      chk(done == 1'b0, "R7 done lasts one cycle", done, 0);
      chk(tone == exp_tone, "R11 tone held after frame", tone, exp_tone);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
      $finish;
   end

   initial begin
      void'($urandom(32'd7041));
      repeat (3) @(negedge clk);
      chk(tone == 1'b0, "R1 tone reset", tone, 0);
      chk(busy == 1'b0, "R1 busy reset", busy, 0);
      chk(done == 1'b0, "R1 done reset", done, 0);
      chk(in_ready == 1'b0, "R1 in_ready reset", in_ready, 0);
      rst_n = 1'b1;
      @(negedge clk);

      pn = 0; run_frame(1, 1);                                   // R8
      pn = 1; pay[0] = 8'hFF; run_frame(0, 0);                   // R5 inside a byte
      pn = 2; pay[0] = 8'hF8; pay[1] = 8'h01; run_frame(0, 1);   // R5 across boundary
      pn = 2; pay[0] = 8'h3C; pay[1] = 8'hF8; run_frame(0, 0);   // R6 trailing run
      pn = 2; pay[0] = 8'h7E; pay[1] = 8'h7E; run_frame(0, 1);
      for (int f = 0; f < 7; f++) begin
         pn = 1 + ($urandom % 6);
         for (int i = 0; i < pn; i++)
            pay[i] = ($urandom % 2) ? 8'($urandom | $urandom) : 8'($urandom);
         run_frame(0, (f % 2) == 0);
         repeat ($urandom % 4) @(negedge clk);
      end
      report();
      $finish;
   end

endmodule